// File: doc/BRIEF.md
# Three-Stage Serial Clock Divider

This block derives the bit timing of a two-wire bus master from the system clock. A programmable half-period counter comes first. A power-of-two prescaler and a linear divider follow it. A final phase stage then splits every bit into twenty half-period slots, which gives the fixed factor of ten on top of the factor of two. One bit period lasts 20·(THP+1)·2^N·(M+1) system cycles. THP is an 8-bit high-period setting. M and N come from a clock-control byte.

The protocol engine sits next to this block. It uses `bit_tick` to advance one bit and `quarter_strobe` to place its SCL and SDA edges at four evenly spaced points inside the bit. Software picks the divider values for a target rate. The block samples the setting only at a bit boundary, so a change made mid-bit never shortens or stretches the bit in progress.

Top module: `sclk_rate_gen`

## Requirements
- R1: While no reset is applied, `bit_tick` is a one-cycle pulse that repeats every 20·(T+1)·2^N·(M+1) clock cycles. T, M and N are the setting in force for that bit period.
- R2: A `half_period` value from 5 to 255 is used as T unchanged. Any value from 0 to 4 is used as T = 5.
- R3: In `clk_ctl`, bits 6:3 carry M (0 to 15) and bits 2:0 carry N (0 to 7). Bit 7 has no effect on either output.
- R4: The first bit period after reset uses T = 24, M = 2, N = 0, which is 1500 cycles. This holds whatever values are on the setting inputs.
- R5: The setting inputs are sampled only on the clock edge that ends a bit period. That sample sets the length of the next period. Changes at any other time have no effect.
- R6: `quarter_strobe` pulses for one cycle at the end of each quarter of a bit period, evenly spaced at one quarter of the period. Its fourth pulse coincides with `bit_tick`.
- R7: Reset is synchronous and active low. On the edge after `rst_n` is sampled low, both outputs are low. Counting restarts from the start of a bit period once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| half_period | input | 8 | High-period setting T, clamped below at 5 |
| clk_ctl | input | 8 | Packed divider byte: M in bits 6:3, N in bits 2:0 |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit period |
| quarter_strobe | output | 1 | One-cycle pulse at the end of each quarter bit |

## Verification
The bound checker checks several properties on every cycle:
- each pulse lasts one cycle;
- every bit tick coincides with a quarter strobe;
- exactly three strobes come between consecutive ticks;
- no two strobes are closer than the smallest legal quarter (30 cycles);
- outputs stay quiet after reset.

The bench's reference model is the only check on the exact period for each setting. The same goes for clamping of small THP values, the ignored top bit of the control byte, the reset defaults, and the rule that a setting changed mid-bit takes effect only at the next boundary.

// File: rtl/sclk_div_pkg.sv
// Package: shared widths, reset defaults and the active-setting type for
// the serial clock divider. Assumes the packed control byte layout
// M = bits 6:3, N = bits 2:0.
package sclk_div_pkg;
    localparam int HP_W     = 8;   // width of the high-period setting
    localparam int MUL_W    = 4;   // width of the linear factor field
    localparam int EXP_W    = 3;   // width of the power-of-two exponent
    localparam int CTL_W    = 8;   // width of the packed control byte
    localparam int MUL_LSB  = EXP_W;

    typedef struct packed {
        logic [HP_W-1:0]  hp;   // half-period count minus one (clamped)
        logic [MUL_W-1:0] mul;  // linear divide minus one
        logic [EXP_W-1:0] exp;  // prescaler exponent
    } div_cfg_t;

    // Clamp a raw high-period value to the smallest usable setting.
    function automatic logic [HP_W-1:0] clamp_hp(input logic [HP_W-1:0] raw,
                                                 input logic [HP_W-1:0] floor_v);
        return (raw < floor_v) ? floor_v : raw;
    endfunction
endpackage

// File: rtl/sclk_cfg_hold.sv
// Module: holds the divider setting in force for the current bit period.
// Decodes the packed control byte, clamps the high period, and reloads
// only when `load` (the bit-period boundary) is high. Reset loads the
// default setting.
module sclk_cfg_hold
    import sclk_div_pkg::*;
#(
    parameter logic [HP_W-1:0]  HP_FLOOR = 8'd5,
    parameter logic [HP_W-1:0]  HP_DEF   = 8'h18,
    parameter logic [MUL_W-1:0] MUL_DEF  = 4'd2,
    parameter logic [EXP_W-1:0] EXP_DEF  = 3'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [HP_W-1:0]  hp_raw,
    input  logic [CTL_W-1:0] ctl_raw,
    output div_cfg_t         cfg
);
    div_cfg_t next_cfg;

    // Decode the raw inputs into the next candidate setting.
    always_comb begin
        next_cfg.hp  = clamp_hp(hp_raw, HP_FLOOR);
        next_cfg.mul = ctl_raw[MUL_LSB +: MUL_W];
        next_cfg.exp = ctl_raw[EXP_W-1:0];
    end

    // Hold the active setting; swap only at a bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.hp  <= HP_DEF;
            cfg.mul <= MUL_DEF;
            cfg.exp <= EXP_DEF;
        end else if (load) begin
            cfg <= next_cfg;
        end
    end
endmodule

// File: rtl/sclk_mod_counter.sv
// Module: free-running modulo counter with a run-time limit. It counts
// enabled cycles from 0 to `limit` and flags `wrap` on the enabled cycle
// that holds `limit`. Used for the half-period and linear stages.
module sclk_mod_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt;

    // Terminal condition of this stage.
    always_comb wrap = en && (cnt == limit);

    // Advance on enable, return to zero at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wrap)  cnt <= '0;
        else if (en)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sclk_pow2_prescale.sv
// Module: power-of-two prescaler. It passes one of every 2^exp enabled
// pulses. The count mask is built from the exponent, so no divider
// logic is needed. Assumes exp never exceeds 2^EXP_W - 1.
module sclk_pow2_prescale #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [EXP_W-1:0] exp,
    output logic             wrap
);
    localparam int CW = (1 << EXP_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] mask;

    // Terminal count is 2^exp - 1, formed as a low-bit mask.
    always_comb begin
        mask = ~({CW{1'b1}} << exp);
        wrap = en && (cnt == mask);
    end

    // Count enabled pulses modulo 2^exp.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wrap)  cnt <= '0;
        else if (en)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sclk_phase_gen.sv
// Module: final stage. It counts SLOTS half-period units per bit and
// registers a bit pulse on the last slot and a quarter pulse on every
// SLOTS/4-th slot. Assumes SLOTS is a multiple of four.
module sclk_phase_gen #(
    parameter int SLOTS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bit_end,
    output logic bit_tick,
    output logic quarter_strobe
);
    localparam int SW  = $clog2(SLOTS);
    localparam int QTR = SLOTS / 4;
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
    localparam logic [SW-1:0] QLST = SW'(QTR - 1);
    localparam logic [SW-1:0] QTRV = SW'(QTR);

    logic [SW-1:0] slot;
    logic          q_end;

    // Detect the bit end and the quarter ends.
    always_comb begin
        bit_end = en && (slot == LAST);
        q_end   = en && ((slot % QTRV) == QLST);
    end

    // Step the slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        slot <= '0;
        else if (bit_end)  slot <= '0;
        else if (en)       slot <= slot + 1'b1;
    end

    // Register the output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_tick       <= 1'b0;
            quarter_strobe <= 1'b0;
        end else begin
            bit_tick       <= bit_end;
            quarter_strobe <= q_end;
        end
    end
endmodule

// File: rtl/sclk_rate_gen.sv
// Module: top of the three-stage serial clock divider. One bit period is
// 2*LIN_FACTOR*(hp+1)*2^exp*(mul+1) clock cycles. The setting is swapped
// only when a bit period ends. Assumes a single clock domain and a
// synchronous active-low reset.
module sclk_rate_gen
    import sclk_div_pkg::*;
#(
    parameter int               LIN_FACTOR = 10,
    parameter logic [HP_W-1:0]  HP_FLOOR   = 8'd5,
    parameter logic [HP_W-1:0]  HP_DEF     = 8'h18,
    parameter logic [MUL_W-1:0] MUL_DEF    = 4'd2,
    parameter logic [EXP_W-1:0] EXP_DEF    = 3'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HP_W-1:0]  half_period,
    input  logic [CTL_W-1:0] clk_ctl,
    output logic             bit_tick,
    output logic             quarter_strobe
);
    localparam int SLOTS = 2 * LIN_FACTOR;

    div_cfg_t cfg;
    logic     half_wrap;
    logic     pre_wrap;
    logic     lin_wrap;
    logic     bit_end;

    sclk_cfg_hold #(
        .HP_FLOOR(HP_FLOOR), .HP_DEF(HP_DEF),
        .MUL_DEF(MUL_DEF),   .EXP_DEF(EXP_DEF)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(bit_end),
        .hp_raw(half_period), .ctl_raw(clk_ctl), .cfg(cfg)
    );

    sclk_mod_counter #(.W(HP_W)) u_half (
        .clk(clk), .rst_n(rst_n), .en(1'b1),
        .limit(cfg.hp), .wrap(half_wrap)
    );

    sclk_pow2_prescale #(.EXP_W(EXP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(half_wrap),
        .exp(cfg.exp), .wrap(pre_wrap)
    );

    sclk_mod_counter #(.W(MUL_W)) u_lin (
        .clk(clk), .rst_n(rst_n), .en(pre_wrap),
        .limit(cfg.mul), .wrap(lin_wrap)
    );

    sclk_phase_gen #(.SLOTS(SLOTS)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(lin_wrap),
        .bit_end(bit_end), .bit_tick(bit_tick),
        .quarter_strobe(quarter_strobe)
    );
endmodule

// File: rtl/sclk_rate_gen_chk.sv
// Checker: cycle-by-cycle properties on the divider outputs. It is
// attached to every instance of the top module through bind.
module sclk_rate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic quarter_strobe
);
    logic [1:0]  q_seen;
    logic [15:0] gap;

    // Count strobes since the last bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n)              q_seen <= '0;
        else if (bit_tick)       q_seen <= '0;
        else if (quarter_strobe) q_seen <= q_seen + 1'b1;
    end

    // Cycles since the previous strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              gap <= '0;
        else if (quarter_strobe) gap <= 16'd1;
        else if (gap != 16'hFFFF) gap <= gap + 1'b1;
    end

    assert_bit_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
    assert_quarter_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        quarter_strobe |=> !quarter_strobe);
    assert_bit_has_quarter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> quarter_strobe);
    assert_three_before_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (q_seen == 2'd3));
    assert_min_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        quarter_strobe |-> (gap >= 16'd30));
    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |=> (!bit_tick && !quarter_strobe));
endmodule

bind sclk_rate_gen sclk_rate_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .bit_tick(bit_tick), .quarter_strobe(quarter_strobe)
);

// File: tb/sclk_rate_gen_tb_top.sv
module sclk_rate_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] half_period = 8'd5;
    logic [7:0] clk_ctl = 8'd0;
    logic       bit_tick;
    logic       quarter_strobe;

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R7";
    bit    armed = 1'b0;
    bit    done = 1'b0;

    longint pos = 0;
    longint per = 1500;   // R4 default period
    logic   exp_bit = 1'b0;
    logic   exp_q = 1'b0;

    always #5 clk = ~clk;

    sclk_rate_gen dut_i (
        .clk(clk), .rst_n(rst_n), .half_period(half_period),
        .clk_ctl(clk_ctl), .bit_tick(bit_tick), .quarter_strobe(quarter_strobe)
    );

    // Period in cycles from the requirements (R1, R2, R3).
    function automatic longint calc_period(input logic [7:0] hp, input logic [7:0] ctl);
        longint t = (hp < 8'd5) ? 5 : hp;
        longint m = ctl[6:3];
        longint n = ctl[2:0];
        return 20 * (t + 1) * (longint'(1) << n) * (m + 1);
    endfunction

    // Behavioural reference: position inside the current bit period.
    always @(posedge clk) begin
        armed = 1'b1;
        if (!rst_n) begin
            pos = 0; per = 1500; exp_bit = 1'b0; exp_q = 1'b0;
        end else begin
            exp_bit = (pos == per - 1);
            exp_q   = (((pos + 1) % (per / 4)) == 0);
            if (pos == per - 1) begin
                pos = 0;
                per = calc_period(half_period, clk_ctl); // R5 sample at boundary
            end else begin
                pos = pos + 1;
            end
        end
    end

    // Compare on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            n_checks++;
            if (bit_tick !== exp_bit || quarter_strobe !== exp_q) begin
                n_fail++;
                $display("FAIL %s: bit_tick=%b quarter=%b expected bit_tick=%b quarter=%b at t=%0t",
                         tag, bit_tick, quarter_strobe, exp_bit, exp_q, $time);
            end
        end
    end

    task automatic run(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tag = "R7 reset outputs low";
        run(5);
        rst_n = 1'b1;
        tag = "R4 default first period";     // inputs say 120, first bit is 1500
        run(2000);
        tag = "R2 clamp below 5";
        half_period = 8'd0;
        run(700);
        tag = "R1 R3 fields T7 M1 N2";
        half_period = 8'd7; clk_ctl = 8'h0A;
        run(4000);
        tag = "R3 bit 7 ignored";
        clk_ctl = 8'h8A;
        run(3000);
        tag = "R5 mid-period changes";
        for (int i = 0; i < 80; i++) begin
            half_period = (i % 2 == 0) ? 8'd9 : 8'd6;
            clk_ctl = (i % 3 == 0) ? 8'h08 : 8'h01;
            run(37);
        end
        tag = "R2 max T 255";
        half_period = 8'd255; clk_ctl = 8'h00;
        run(12000);
        tag = "R3 M 15";
        half_period = 8'd5; clk_ctl = 8'h78;
        run(5000);
        tag = "R3 N 7";
        clk_ctl = 8'h07;
        run(32000);
        tag = "R7 mid-run reset";
        @(negedge clk); rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        tag = "R4 defaults after reset";
        run(2000);
        tag = "R6 quarters T5";
        half_period = 8'd5; clk_ctl = 8'h00;
        run(1000);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule